// File: doc/BRIEF.md
# Bit-Serial Memory Access Sequencer

This block sits beside a processor and drives a nonvolatile memory that exchanges data over a single data line. The memory is addressed with ordinary bus read and write strobes, and each strobe moves exactly one bit. The sequencer accepts three kinds of request: read a run of bytes from an address, program up to one page of bytes, and poll for the end of a programming cycle. It turns each request into the exact series of single-bit bus cycles the memory expects. Chip enable, output enable and write enable have programmable setup, pulse and gap lengths. Chip enable is released between every pair of cycles so that other traffic can use the bus.

A read or write access opens with a framing triple that resynchronises the memory. Sixteen address bits follow, most significant first. A read then collects eight bits per byte, most significant first, and hands each byte out on a valid/ready stream. It closes with a single write cycle carrying 1. A write takes its bytes from a valid/ready stream and shifts each one out most significant bit first. It closes with a commit triple that starts programming. A poll issues bare read cycles until the line reads 1, and gives up after a set number of attempts.

A write request that is empty or that would run past the end of its page is refused at once and causes no bus activity. A read of zero bytes and an unknown opcode are refused in the same way.

Top module: `serial_mem_sequencer`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), the data driver is off, `req_ready` is high, and `rd_valid`, `wr_ready`, `done`, `req_err` and `poll_fault` are low.
- R2: A read request (`req_op`=0) and a write request (`req_op`=1) both begin with three bus cycles in this order: a read, a write carrying 0, a read.
- R3: Straight after that triple, the sequencer issues 16 write cycles carrying `req_addr`, bit 15 first, with no read cycle among them.
- R4: A read request for N bytes issues 8·N read cycles. It assembles each byte from the first sampled bit (bit 7) to the last (bit 0), delivers the bytes in order on `rd_data`, then issues one write cycle carrying 1 and pulses `done`.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold and no bus cycle starts.
- R6: A write request for N bytes takes N bytes from the write stream. It sends each as 8 write cycles, bit 7 first, then issues read, write carrying 1, read, and pulses `done`.
- R7: A request is refused with a one-cycle `req_err` pulse, with no bus cycle and no `done`, when any of these holds: it is a write whose page offset (`req_addr[4:0]` for 32-byte pages) plus its length exceeds 32, it is a read or write of length 0, or its opcode is 3.
- R8: A poll request (`req_op`=2) issues only read cycles, with no framing triple. It stops and pulses `done` after the first cycle that samples 1 on `mem_din`.
- R9: If POLL_MAX consecutive poll reads sample 0, the sequencer pulses `poll_fault` instead of `done` and becomes ready again.
- R10: Output enable and write enable are never low together. Either strobe is low only while chip enable is low and only after SETUP_CYC cycles of chip enable alone. Each strobe pulse lasts exactly PULSE_CYC cycles, and chip enable stays high for at least GAP_CYC cycles between bus cycles.
- R11: During a write cycle the data driver is on whenever write enable is low, and `mem_dout` does not change while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_op | input | 2 | 0 read, 1 page write, 2 poll, 3 refused |
| req_addr | input | AW | Start byte address |
| req_len | input | LEN_W | Byte count for read or write |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Sequencer takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse when a request completes |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| poll_fault | output | 1 | One-cycle pulse when polling times out |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dout | output | 1 | Bit driven onto the data line |
| mem_doe | output | 1 | Data line driver enable |
| mem_din | input | 1 | Bit sampled from the data line |

## Verification
The bound checker watches the strobe discipline on every cycle. It confirms that output enable and write enable never overlap, that both stay inside chip enable after a setup gap, that each pulse has the right width, and that the driver is on and the data stable during writes. It also confirms that a stalled read byte holds with the bus quiet, and that a refusal or a poll fault never comes with `done`. Only the bench's scenarios can show that the cycle sequence is right: the framing triples, the address order, the bit order inside bytes, the closing write of 1, the commit triple, page-limit refusal, and poll stop and timeout counts. The bench records every bus cycle as a read, or as a write together with its bit, and compares this log with the sequence it expects for each request. It runs these scenarios under random backpressure on both data streams.

// File: rtl/serial_mem_sequencer.sv
module serial_mem_sequencer #(
  parameter int AW         = 16,
  parameter int LEN_W      = 7,
  parameter int PAGE_BYTES = 32,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int GAP_CYC    = 1,
  parameter int POLL_MAX   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             req_err,
  output logic             poll_fault,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dout,
  output logic             mem_doe,
  input  logic             mem_din
);

  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int SW   = LEN_W + 1;
  localparam int TMAX = (SETUP_CYC > PULSE_CYC) ? ((SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC)
                                                : ((PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(AW);
  localparam int PW   = $clog2(POLL_MAX + 1);

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_POLL  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_ADDR, S_RDAT, S_RTERM, S_WDAT, S_COMMIT, S_POLL} seq_t;
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_GAP} bus_t;

  seq_t             st;
  bus_t             bst;
  logic [TW-1:0]    tcnt;
  logic [IW-1:0]    idx;
  logic [AW-1:0]    addr_sr;
  logic [7:0]       byte_sr;
  logic [7:0]       rbyte;
  logic [LEN_W-1:0] left;
  logic [PW-1:0]    pcnt;
  logic             is_wr, have_byte, rvalid;
  logic             c_wr, c_bit;
  logic             done_r, err_r, flt_r;

  logic need, n_wr, n_bit, start, cyc_end, accept, refuse;
  logic [SW-1:0] span;

  always_comb begin
    need  = 1'b0;
    n_wr  = 1'b0;
    n_bit = 1'b1;
    case (st)
      S_FRAME:  begin need = 1'b1; n_wr = (idx == IW'(1)); n_bit = 1'b0; end
      S_ADDR:   begin need = 1'b1; n_wr = 1'b1; n_bit = addr_sr[AW-1]; end
      S_RDAT:   need = !rvalid;
      S_RTERM:  begin need = 1'b1; n_wr = 1'b1; end
      S_WDAT:   begin need = have_byte; n_wr = 1'b1; n_bit = byte_sr[7]; end
      S_COMMIT: begin need = 1'b1; n_wr = (idx == IW'(1)); end
      S_POLL:   need = 1'b1;
      default:  need = 1'b0;
    endcase
  end

  assign span    = SW'(req_addr[PG_W-1:0]) + SW'(req_len);
  assign refuse  = (req_op == 2'd3)
                || ((req_op != OP_POLL) && (req_len == '0))
                || ((req_op == OP_WRITE) && (span > SW'(PAGE_BYTES)));
  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = (bst == B_IDLE) && need;
  assign cyc_end   = (bst == B_PULSE) && (tcnt == TW'(PULSE_CYC - 1));
  assign wr_ready  = (st == S_WDAT) && !have_byte && (bst == B_IDLE);

  assign mem_ce_n = !((bst == B_SETUP) || (bst == B_PULSE));
  assign mem_oe_n = !((bst == B_PULSE) && !c_wr);
  assign mem_we_n = !((bst == B_PULSE) && c_wr);
  assign mem_dout = c_bit;
  assign mem_doe  = c_wr && (bst != B_IDLE);

  assign rd_valid   = rvalid;
  assign rd_data    = rbyte;
  assign done       = done_r;
  assign req_err    = err_r;
  assign poll_fault = flt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst   <= B_IDLE;
      tcnt  <= '0;
      c_wr  <= 1'b0;
      c_bit <= 1'b1;
    end else begin
      case (bst)
        B_IDLE: if (start) begin
          bst   <= B_SETUP;
          tcnt  <= '0;
          c_wr  <= n_wr;
          c_bit <= n_bit;
        end
        B_SETUP: if (tcnt == TW'(SETUP_CYC - 1)) begin
          bst  <= B_PULSE;
          tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
        B_PULSE: if (cyc_end) begin
          bst  <= B_GAP;
          tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
        default: if (tcnt == TW'(GAP_CYC - 1)) begin
          bst  <= B_IDLE;
          tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      addr_sr   <= '0;
      byte_sr   <= '0;
      rbyte     <= '0;
      left      <= '0;
      pcnt      <= '0;
      is_wr     <= 1'b0;
      have_byte <= 1'b0;
      rvalid    <= 1'b0;
      done_r    <= 1'b0;
      err_r     <= 1'b0;
      flt_r     <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      flt_r  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (refuse) err_r <= 1'b1;
          else begin
            addr_sr <= req_addr;
            left    <= req_len;
            is_wr   <= (req_op == OP_WRITE);
            idx     <= '0;
            pcnt    <= '0;
            st      <= (req_op == OP_POLL) ? S_POLL : S_FRAME;
          end
        end
        S_FRAME: if (cyc_end) begin
          if (idx == IW'(2)) begin
            idx <= '0;
            st  <= S_ADDR;
          end else idx <= idx + 1'b1;
        end
        S_ADDR: if (cyc_end) begin
          addr_sr <= addr_sr << 1;
          if (idx == IW'(AW - 1)) begin
            idx <= '0;
            st  <= is_wr ? S_WDAT : S_RDAT;
          end else idx <= idx + 1'b1;
        end
        S_RDAT: begin
          if (cyc_end) begin
            rbyte <= {rbyte[6:0], mem_din};
            if (idx == IW'(7)) begin
              idx    <= '0;
              rvalid <= 1'b1;
            end else idx <= idx + 1'b1;
          end
          if (rvalid && rd_ready) begin
            rvalid <= 1'b0;
            left   <= left - 1'b1;
            if (left == LEN_W'(1)) st <= S_RTERM;
          end
        end
        S_RTERM: if (cyc_end) begin
          st     <= S_IDLE;
          done_r <= 1'b1;
        end
        S_WDAT: begin
          if (wr_ready && wr_valid) begin
            byte_sr   <= wr_data;
            have_byte <= 1'b1;
          end
          if (cyc_end) begin
            byte_sr <= byte_sr << 1;
            if (idx == IW'(7)) begin
              idx       <= '0;
              have_byte <= 1'b0;
              left      <= left - 1'b1;
              if (left == LEN_W'(1)) st <= S_COMMIT;
            end else idx <= idx + 1'b1;
          end
        end
        S_COMMIT: if (cyc_end) begin
          if (idx == IW'(2)) begin
            idx    <= '0;
            st     <= S_IDLE;
            done_r <= 1'b1;
          end else idx <= idx + 1'b1;
        end
        S_POLL: if (cyc_end) begin
          if (mem_din) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            st    <= S_IDLE;
            flt_r <= 1'b1;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_mem_sequencer_chk.sv
module serial_mem_sequencer_chk #(
  parameter int PULSE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       req_err,
  input logic       poll_fault,
  input logic       mem_ce_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       mem_dout,
  input logic       mem_doe
);

  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!mem_oe_n || !mem_we_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  a_r10_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r10_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);
  a_r10_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n & mem_we_n) |-> $past(!mem_ce_n));
  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n & mem_we_n) |-> (low_cnt == 8'(PULSE_CYC)));
  a_r11_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_doe);
  a_r11_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_dout));
  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r5_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> mem_ce_n);
  a_r7_refuse_alone: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!done && mem_ce_n && req_ready));
  a_r9_fault_alone: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fault |-> !done);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

endmodule

bind serial_mem_sequencer serial_mem_sequencer_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .req_err(req_err),
  .poll_fault(poll_fault), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe)
);

// File: tb/serial_mem_sequencer_tb.sv
module serial_mem_sequencer_tb_top;

  localparam int SETUP = 1;
  localparam int PULSE = 2;
  localparam int GAP   = 1;
  localparam int PMAX  = 20;
  localparam int LOGN  = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [6:0]  req_len = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        done, req_err, poll_fault;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout, mem_doe, mem_din;

  serial_mem_sequencer #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .GAP_CYC(GAP), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .req_err(req_err), .poll_fault(poll_fault), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic log_w [LOGN];
  logic log_b [LOGN];
  int   n_log = 0, n_rd = 0, mon_bad = 0;
  logic src_bits [LOGN];
  int   src_base = 0, log_base = 0;
  logic exp_w [LOGN];
  logic exp_b [LOGN];
  int   n_exp = 0;
  logic [7:0] bytes [128];

  function automatic logic src_at(input int k);
    if (k >= 0 && k < LOGN) return src_bits[k];
    return 1'b1;
  endfunction

  assign mem_din = (!mem_ce_n && !mem_oe_n) ? src_at(n_rd - src_base) : 1'b1;

  logic prev_ce = 1'b1, saw_w = 1'b0, saw_r = 1'b0, wbit = 1'b0;
  int   low_len = 0, high_len = 100;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        if (prev_ce && high_len < GAP) mon_bad++;
        high_len = 0;
        low_len++;
        if (!mem_oe_n && !mem_we_n) mon_bad++;
        if (!mem_we_n) begin
          saw_w = 1'b1;
          wbit  = mem_dout;
          if (!mem_doe) mon_bad++;
        end
        if (!mem_oe_n) saw_r = 1'b1;
      end else begin
        if (!prev_ce) begin
          if (low_len != SETUP + PULSE) mon_bad++;
          if (saw_w == saw_r) mon_bad++;
          if (n_log < LOGN) begin
            log_w[n_log] = saw_w;
            log_b[n_log] = wbit;
          end
          n_log++;
          if (saw_r) n_rd++;
          saw_w = 1'b0;
          saw_r = 1'b0;
          low_len = 0;
        end
        high_len++;
      end
      prev_ce = mem_ce_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic b);
    exp_w[n_exp] = w;
    exp_b[n_exp] = b;
    n_exp++;
  endtask

  task automatic push_frame(input logic [15:0] a);
    push(1'b0, 1'b0);
    push(1'b1, 1'b0);
    push(1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) push(1'b1, a[i]);
  endtask

  function automatic int trace_mismatch();
    for (int i = 0; i < n_exp; i++) begin
      if (log_w[log_base + i] != exp_w[i]) return i;
      if (exp_w[i] && log_b[log_base + i] != exp_b[i]) return i;
    end
    return -1;
  endfunction

  task automatic compare_trace(input string req);
    int mm;
    chk(n_log - log_base == n_exp, req, "bus cycle count", n_log - log_base, n_exp);
    if (n_log - log_base == n_exp) begin
      mm = trace_mismatch();
      chk(mm < 0, req, "first wrong bus cycle index", mm, -1);
    end
  endtask

  task automatic begin_txn();
    log_base = n_log;
    src_base = n_rd;
    n_exp = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_len   = 7'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    int got = 0;
    bit fin = 0;
    begin_txn();
    src_bits[0] = 1'b1;
    src_bits[1] = 1'b1;
    for (int i = 0; i < n; i++) begin
      bytes[i] = 8'($urandom);
      for (int j = 0; j < 8; j++) src_bits[2 + 8*i + j] = bytes[i][7-j];
    end
    push_frame(a);
    for (int i = 0; i < 8*n; i++) push(1'b0, 1'b0);
    push(1'b1, 1'b1);
    issue(2'd0, a, n);
    while (!fin) begin
      if (rd_valid) begin
        rd_ready = ($urandom % 4) != 0;
        if (rd_ready) begin
          if (got < n) chk(rd_data == bytes[got], "R4", "read byte", int'(rd_data), int'(bytes[got]));
          got++;
        end
      end else rd_ready = 1'b0;
      if (done) fin = 1;
      @(negedge clk);
    end
    rd_ready = 1'b0;
    repeat (GAP + 3) @(negedge clk);
    chk(got == n, "R4", "bytes delivered", got, n);
    compare_trace("R2 R3 R4");
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    int widx = 0;
    bit fin = 0;
    begin_txn();
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    push_frame(a);
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) push(1'b1, bytes[i][j]);
    push(1'b0, 1'b0);
    push(1'b1, 1'b1);
    push(1'b0, 1'b0);
    issue(2'd1, a, n);
    while (!fin) begin
      if (wr_ready && widx < n && ($urandom % 3) != 0) begin
        wr_valid = 1'b1;
        wr_data  = bytes[widx];
        widx++;
      end else wr_valid = 1'b0;
      if (done) fin = 1;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    repeat (GAP + 3) @(negedge clk);
    chk(widx == n, "R6", "bytes taken", widx, n);
    compare_trace("R2 R3 R6");
  endtask

  task automatic do_poll(input int k);
    bit fin = 0, saw_done = 0, saw_flt = 0;
    int nreads;
    begin_txn();
    for (int i = 0; i < k; i++) src_bits[i] = 1'b0;
    src_bits[k] = 1'b1;
    nreads = (k < PMAX) ? k + 1 : PMAX;
    for (int i = 0; i < nreads; i++) push(1'b0, 1'b0);
    issue(2'd2, 16'h0, 0);
    while (!fin) begin
      if (done) begin saw_done = 1; fin = 1; end
      if (poll_fault) begin saw_flt = 1; fin = 1; end
      @(negedge clk);
    end
    repeat (GAP + 3) @(negedge clk);
    if (k < PMAX) begin
      chk(saw_done && !saw_flt, "R8", "poll done pulse", int'(saw_done), 1);
      compare_trace("R8");
    end else begin
      chk(saw_flt && !saw_done, "R9", "poll fault pulse", int'(saw_flt), 1);
      compare_trace("R9");
    end
  endtask

  task automatic do_bad(input logic [1:0] op, input logic [15:0] a, input int n);
    int quiet_done = 0;
    begin_txn();
    issue(op, a, n);
    chk(req_err == 1'b1, "R7", "refusal pulse", int'(req_err), 1);
    repeat (30) begin
      @(negedge clk);
      if (done) quiet_done++;
    end
    chk(n_log == log_base && quiet_done == 0 && req_ready, "R7",
        "bus cycles after refusal", n_log - log_base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7919));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_doe, "R1", "bus idle after reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n, mem_doe}), 14);
    chk(req_ready && !rd_valid && !wr_ready && !done && !req_err && !poll_fault, "R1",
        "handshake idle after reset", int'(req_ready), 1);

    do_read(16'hA5C3, 1);
    do_read(16'hFFFF, 3);
    do_write(16'h0040, 32);
    do_write(16'h127F, 1);
    do_poll(0);
    do_poll(5);
    do_poll(PMAX - 1);
    do_poll(PMAX + 4);
    do_bad(2'd1, 16'h001F, 2);
    do_bad(2'd1, 16'h0000, 33);
    do_bad(2'd0, 16'h1234, 0);
    do_bad(2'd1, 16'h1234, 0);
    do_bad(2'd3, 16'h0000, 4);

    for (int it = 0; it < 24; it++) begin
      int sel, n, off;
      sel = $urandom % 4;
      case (sel)
        0: do_read(16'($urandom), 1 + ($urandom % 10));
        1: begin
          n   = 1 + ($urandom % 32);
          off = $urandom % (33 - n);
          do_write({11'($urandom), 5'(off)}, n);
        end
        2: do_poll($urandom % 9);
        default: begin
          n   = 2 + ($urandom % 20);
          off = 33 - n + ($urandom % (n - 1));
          do_bad(2'd1, {11'($urandom), 5'(off)}, n);
        end
      endcase
    end

    chk(mon_bad == 0, "R10 R11", "strobe timing or drive violations", mon_bad, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule